// File: doc/BRIEF.md
# Register File with Pointer Addressing

This block is the general register file of a small load/store processor core. It holds thirty-two 8-bit registers. Two read ports return register contents in the same cycle, and one write port updates a register at the next rising clock edge. The six highest registers double as three 16-bit address pointers. An address-generation port reads one pointer and forms the effective data address from it. In the increment and decrement modes it also writes the adjusted pointer back.

The block also serves the bottom of the data address space. Accesses to data addresses 0x0000–0x001F are steered onto the registers, so ordinary loads and stores can reach them. A word-immediate port adds or subtracts a small unsigned constant on one of the four highest register pairs. A single error output flags any request the register set cannot honour, and the block drops the write of that request.

Top module: `gpr_ptr_file`

## Requirements
- R1: After reset every register reads as 0x00.
- R2: `rd_a_data` and `rd_b_data` show the register named by their index in the same cycle. A read of a register that is being written in that cycle returns the value it held before the edge.
- R3: A write-port request lands at the next rising edge. When `wr_imm` is 1, the target must be R16–R31; a target of R0–R15 raises `err` and leaves the register unchanged.
- R4: The pointer select codes are 0 for R27:R26, 1 for R29:R28 and 2 for R31:R30, with the even register as the low byte. Code 3 is reserved: it raises `err`, drives `ag_addr` to 0 and writes nothing. Mode 0 (plain) puts the pointer on `ag_addr` and leaves it unchanged.
- R5: Mode 1 (post-increment) puts the pointer on `ag_addr` and stores pointer+1 at the edge. 0xFFFF wraps to 0x0000.
- R6: Mode 2 (pre-decrement) puts pointer−1 on `ag_addr` and stores that value at the edge. 0x0000 wraps to 0xFFFF.
- R7: Mode 3 (displacement) puts the pointer plus the zero-extended 6-bit `ag_disp` on `ag_addr`, modulo 2^16, and leaves the pointer unchanged. With select 0 it raises `err` and puts the plain pointer on `ag_addr`.
- R8: With `dm_en` high, `dm_hit` is 1 exactly when `dm_addr` < 0x0020. On a hit, `dm_rdata` is register `dm_addr[4:0]`, and a store (`dm_we`=1) writes that register at the edge. On a miss, `dm_rdata` is 0x00 and no register changes.
- R9: The word-immediate port accepts base 24, 26, 28 or 30. It writes the pair (base+1):base with the pair plus `iw_imm` (`iw_sub`=0) or minus `iw_imm` (`iw_sub`=1), modulo 2^16. Any other base raises `err` and writes nothing.
- R10: When several sources write one register in the same cycle, the write port wins, then the data store, then the word-immediate port, then the pointer write-back.
- R11: `err` is 0 whenever no enabled port makes an illegal request, whatever the disabled ports' other inputs are. Disabled ports change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data, combinational |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data, combinational |
| wr_en | input | 1 | Write port enable |
| wr_imm | input | 1 | Write carries an 8-bit immediate (R16–R31 only) |
| wr_idx | input | 5 | Write port register index |
| wr_data | input | 8 | Write port data |
| ag_en | input | 1 | Address-generation request |
| ag_sel | input | 2 | Pointer select (0, 1, 2; 3 reserved) |
| ag_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement, 3 displacement |
| ag_disp | input | 6 | Unsigned displacement |
| ag_addr | output | 16 | Effective address, combinational |
| dm_en | input | 1 | Data access enable |
| dm_we | input | 1 | Data access is a store |
| dm_addr | input | 16 | Data address |
| dm_wdata | input | 8 | Store data |
| dm_hit | output | 1 | Address falls in the register window |
| dm_rdata | output | 8 | Load data from the register window |
| iw_en | input | 1 | Word-immediate request |
| iw_sub | input | 1 | 1 subtracts, 0 adds |
| iw_base | input | 5 | Low register of the target pair |
| iw_imm | input | 6 | Unsigned immediate |
| err | output | 1 | Illegal request flag, combinational |

## Verification
Read data, `ag_addr`, `dm_hit`, `dm_rdata` and `err` are combinational. The bench checks them in the same cycle as the stimulus, one nanosecond after it drives its inputs on the falling edge. Register updates appear one edge later. The bench releases the stimulus at the next falling edge and then reads the affected registers back through the read ports. Reset release passes through a two-stage synchroniser, so the bench waits four cycles after deasserting `rst_n` before it makes the first check.

// File: rtl/gprf_pkg.sv
`timescale 1ns/1ps
package gprf_pkg;
  localparam int unsigned GPRF_DW    = 8;
  localparam int unsigned GPRF_NREG  = 32;
  localparam int unsigned GPRF_AW    = 16;
  localparam int unsigned GPRF_DISPW = 6;

  typedef enum logic [1:0] {
    PM_PLAIN   = 2'd0,
    PM_POSTINC = 2'd1,
    PM_PREDEC  = 2'd2,
    PM_DISP    = 2'd3
  } ptr_mode_e;

  typedef enum logic [1:0] {
    PS_LO   = 2'd0,
    PS_MID  = 2'd1,
    PS_HI   = 2'd2,
    PS_RSVD = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/gprf_agu.sv
`timescale 1ns/1ps
module gprf_agu
  import gprf_pkg::*;
#(
  parameter int AW    = GPRF_AW,
  parameter int DISPW = GPRF_DISPW
) (
  input  logic [AW-1:0]    ptr_q,
  input  ptr_mode_e        mode,
  input  logic [DISPW-1:0] disp,
  input  logic             disp_ok,
  output logic [AW-1:0]    ea,
  output logic [AW-1:0]    ptr_d,
  output logic             upd
);
  always_comb begin
    ea    = ptr_q;
    ptr_d = ptr_q;
    upd   = 1'b0;
    unique case (mode)
      PM_POSTINC: begin
        ptr_d = ptr_q + AW'(1);
        upd   = 1'b1;
      end
      PM_PREDEC: begin
        ptr_d = ptr_q - AW'(1);
        ea    = ptr_q - AW'(1);
        upd   = 1'b1;
      end
      PM_DISP: begin
        if (disp_ok) ea = ptr_q + AW'(disp);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gprf_wimm.sv
`timescale 1ns/1ps
module gprf_wimm
  import gprf_pkg::*;
#(
  parameter int AW   = GPRF_AW,
  parameter int IMMW = GPRF_DISPW
) (
  input  logic [AW-1:0]   pair_q,
  input  logic [IMMW-1:0] imm,
  input  logic            sub,
  output logic [AW-1:0]   res
);
  always_comb begin
    if (sub) res = pair_q - AW'(imm);
    else     res = pair_q + AW'(imm);
  end
endmodule

// File: rtl/gprf_bank.sv
`timescale 1ns/1ps
module gprf_bank
  import gprf_pkg::*;
#(
  parameter int NREG  = GPRF_NREG,
  parameter int DW    = GPRF_DW,
  parameter int NPORT = 6,
  parameter int IW    = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           p_en,
  input  logic [NPORT-1:0][IW-1:0]   p_idx,
  input  logic [NPORT-1:0][DW-1:0]   p_data,
  output logic [NREG-1:0][DW-1:0]    q
);
  // Higher port number has higher priority: later matches overwrite earlier ones.
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          ce_r;
    logic [DW-1:0] d_r;
    logic [DW-1:0] q_r;

    always_comb begin
      ce_r = 1'b0;
      d_r  = q_r;
      for (int p = 0; p < NPORT; p++) begin
        if (p_en[p] && (p_idx[p] == IW'(r))) begin
          ce_r = 1'b1;
          d_r  = p_data[p];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_r <= '0;
      else if (ce_r) q_r <= d_r;
    end

    assign q[r] = q_r;
  end
endmodule

// File: rtl/gpr_ptr_file.sv
`timescale 1ns/1ps
module gpr_ptr_file
  import gprf_pkg::*;
#(
  parameter int NREG     = GPRF_NREG,
  parameter int DW       = GPRF_DW,
  parameter int AW       = GPRF_AW,
  parameter int DISPW    = GPRF_DISPW,
  parameter int PTR_BASE = 26,
  parameter int IMM8_LO  = 16,
  parameter int WIMM_LO  = 24,
  localparam int IW      = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    rd_a_idx,
  output logic [DW-1:0]    rd_a_data,
  input  logic [IW-1:0]    rd_b_idx,
  output logic [DW-1:0]    rd_b_data,
  input  logic             wr_en,
  input  logic             wr_imm,
  input  logic [IW-1:0]    wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             ag_en,
  input  logic [1:0]       ag_sel,
  input  logic [1:0]       ag_mode,
  input  logic [DISPW-1:0] ag_disp,
  output logic [AW-1:0]    ag_addr,
  input  logic             dm_en,
  input  logic             dm_we,
  input  logic [AW-1:0]    dm_addr,
  input  logic [DW-1:0]    dm_wdata,
  output logic             dm_hit,
  output logic [DW-1:0]    dm_rdata,
  input  logic             iw_en,
  input  logic             iw_sub,
  input  logic [IW-1:0]    iw_base,
  input  logic [DISPW-1:0] iw_imm,
  output logic             err
);
  localparam int NPORT = 6;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NREG-1:0][DW-1:0] regs;
  logic [NPORT-1:0]         p_en;
  logic [NPORT-1:0][IW-1:0] p_idx;
  logic [NPORT-1:0][DW-1:0] p_data;

  // Read ports
  assign rd_a_data = regs[rd_a_idx];
  assign rd_b_data = regs[rd_b_idx];

  // Pointer address generation
  ptr_sel_e  sel_e;
  ptr_mode_e mode_e;
  logic          sel_ok, ag_ill, ag_upd, ag_we;
  logic [IW-1:0] ag_lo, ag_hi;
  logic [AW-1:0] ptr_q, ptr_d, ea_raw;

  assign sel_e  = ptr_sel_e'(ag_sel);
  assign mode_e = ptr_mode_e'(ag_mode);
  assign sel_ok = (sel_e != PS_RSVD);
  assign ag_lo  = IW'(PTR_BASE) + IW'({ag_sel, 1'b0});
  assign ag_hi  = ag_lo + IW'(1);
  assign ptr_q  = sel_ok ? {regs[ag_hi], regs[ag_lo]} : '0;
  assign ag_ill = ag_en && (!sel_ok || (sel_e == PS_LO && mode_e == PM_DISP));

  gprf_agu #(.AW(AW), .DISPW(DISPW)) u_agu (
    .ptr_q   (ptr_q),
    .mode    (mode_e),
    .disp    (ag_disp),
    .disp_ok (sel_e != PS_LO),
    .ea      (ea_raw),
    .ptr_d   (ptr_d),
    .upd     (ag_upd)
  );

  assign ag_addr = sel_ok ? ea_raw : '0;
  assign ag_we   = ag_en && ag_upd && !ag_ill;

  // Word immediate on the upper pairs
  logic          iw_ok, iw_ill, iw_we;
  logic [IW-1:0] iw_hi;
  logic [AW-1:0] iw_res;

  assign iw_ok  = (iw_base >= IW'(WIMM_LO)) && !iw_base[0];
  assign iw_ill = iw_en && !iw_ok;
  assign iw_we  = iw_en && iw_ok;
  assign iw_hi  = iw_base + IW'(1);

  gprf_wimm #(.AW(AW), .IMMW(DISPW)) u_wimm (
    .pair_q (AW'({regs[iw_hi], regs[iw_base]})),
    .imm    (iw_imm),
    .sub    (iw_sub),
    .res    (iw_res)
  );

  // Low data-address window
  logic dm_st;
  assign dm_hit   = dm_en && (dm_addr < AW'(NREG));
  assign dm_rdata = dm_hit ? regs[dm_addr[IW-1:0]] : '0;
  assign dm_st    = dm_hit && dm_we;

  // Write port with immediate-target check
  logic wr_ill;
  assign wr_ill = wr_en && wr_imm && (wr_idx < IW'(IMM8_LO));

  assign err = ag_ill || iw_ill || wr_ill;

  // Write sources, lowest priority first
  always_comb begin
    p_en[0] = ag_we;           p_idx[0] = ag_lo;   p_data[0] = ptr_d[DW-1:0];
    p_en[1] = ag_we;           p_idx[1] = ag_hi;   p_data[1] = ptr_d[AW-1:DW];
    p_en[2] = iw_we;           p_idx[2] = iw_base; p_data[2] = iw_res[DW-1:0];
    p_en[3] = iw_we;           p_idx[3] = iw_hi;   p_data[3] = iw_res[AW-1:DW];
    p_en[4] = dm_st;           p_idx[4] = dm_addr[IW-1:0]; p_data[4] = dm_wdata;
    p_en[5] = wr_en && !wr_ill; p_idx[5] = wr_idx; p_data[5] = wr_data;
  end

  gprf_bank #(.NREG(NREG), .DW(DW), .NPORT(NPORT), .IW(IW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .p_en   (p_en),
    .p_idx  (p_idx),
    .p_data (p_data),
    .q      (regs)
  );
endmodule

// File: rtl/gpr_ptr_file_chk.sv
`timescale 1ns/1ps
module gpr_ptr_file_chk #(
  parameter int IW    = 5,
  parameter int DW    = 8,
  parameter int AW    = 16,
  parameter int DISPW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IW-1:0]    rd_a_idx,
  input logic [DW-1:0]    rd_a_data,
  input logic             wr_en,
  input logic             wr_imm,
  input logic [IW-1:0]    wr_idx,
  input logic [DW-1:0]    wr_data,
  input logic             ag_en,
  input logic [1:0]       ag_sel,
  input logic [1:0]       ag_mode,
  input logic [DISPW-1:0] ag_disp,
  input logic [AW-1:0]    ag_addr,
  input logic             dm_en,
  input logic             dm_we,
  input logic [AW-1:0]    dm_addr,
  input logic [DW-1:0]    dm_wdata,
  input logic             dm_hit,
  input logic [DW-1:0]    dm_rdata,
  input logic             iw_en,
  input logic             err
);
  logic only_ag;
  assign only_ag = ag_en && !wr_en && !dm_en && !iw_en;

  p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && !(wr_imm && wr_idx < IW'(16))) && rd_a_idx == $past(wr_idx))
      |-> rd_a_data == $past(wr_data));

  p_postinc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(only_ag && ag_mode == 2'd1 && ag_sel != 2'd3) && ag_en &&
     ag_mode == 2'd0 && ag_sel == $past(ag_sel))
      |-> ag_addr == $past(ag_addr) + AW'(1));

  p_predec_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(only_ag && ag_mode == 2'd2 && ag_sel != 2'd3) && ag_en &&
     ag_mode == 2'd0 && ag_sel == $past(ag_sel))
      |-> ag_addr == $past(ag_addr));

  p_disp_no_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(only_ag && ag_mode == 2'd3 && (ag_sel == 2'd1 || ag_sel == 2'd2)) &&
     ag_en && ag_mode == 2'd0 && ag_sel == $past(ag_sel))
      |-> ag_addr == $past(ag_addr) - $past(AW'(ag_disp)));

  p_disp_lo_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ag_en && ag_sel == 2'd0 && ag_mode == 2'd3) |-> err);

  p_store_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dm_en && dm_we && dm_addr < AW'(32) && !wr_en) && dm_en &&
     dm_addr == $past(dm_addr))
      |-> dm_rdata == $past(dm_wdata));

  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_en && dm_addr >= AW'(32)) |-> (!dm_hit && dm_rdata == '0));
endmodule

bind gpr_ptr_file gpr_ptr_file_chk u_chk (.*);

// File: tb/gpr_ptr_file_test.sv
`timescale 1ns/1ps
module gpr_ptr_file_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx, iw_base;
  logic [7:0]  rd_a_data, rd_b_data, wr_data, dm_wdata, dm_rdata;
  logic        wr_en, wr_imm, ag_en, dm_en, dm_we, dm_hit, iw_en, iw_sub, err;
  logic [1:0]  ag_sel, ag_mode;
  logic [5:0]  ag_disp, iw_imm;
  logic [15:0] ag_addr, dm_addr;

  int  vecs = 0;
  int  miss = 0;
  bit  done = 1'b0;
  logic [7:0] mdl [32];

  always #4 clk = ~clk;

  gpr_ptr_file uut (.*);

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %h, expected %h", req, got, exp);
    end
  endtask

  task automatic quiet();
    wr_en = 0; wr_imm = 0; wr_idx = 0; wr_data = 0;
    ag_en = 0; ag_sel = 0; ag_mode = 0; ag_disp = 0;
    dm_en = 0; dm_we = 0; dm_addr = 0; dm_wdata = 0;
    iw_en = 0; iw_sub = 0; iw_base = 0; iw_imm = 0;
  endtask

  task automatic commit();
    @(negedge clk);
    quiet();
  endtask

  function automatic logic [15:0] pair(input int b);
    return {mdl[(b + 1) % 32], mdl[b]};
  endfunction

  task automatic sweep_regs(input string req);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i);
      rd_b_idx = 5'(31 - i);
      #1;
      chk(req, 16'(rd_a_data), 16'(mdl[i]));
      chk(req, 16'(rd_b_data), 16'(mdl[31 - i]));
      @(negedge clk);
    end
  endtask

  task automatic check_pair(input string req, input int b);
    rd_a_idx = 5'(b);
    rd_b_idx = 5'((b + 1) % 32);
    #1;
    chk(req, {rd_b_data, rd_a_data}, pair(b));
    @(negedge clk);
  endtask

  task automatic load_pair(input int b, input logic [15:0] v);
    wr_en = 1; wr_idx = 5'(b + 1); wr_data = v[15:8];
    dm_en = 1; dm_we = 1; dm_addr = 16'(b); dm_wdata = v[7:0];
    commit();
    mdl[b] = v[7:0];
    mdl[b + 1] = v[15:8];
  endtask

  task automatic do_dm(input logic [15:0] a);
    logic       h;
    logic [7:0] v;
    h = (a < 16'd32);
    v = 8'(int'(a) * 11 + 3) ^ 8'h5A;
    dm_en = 1; dm_we = 1; dm_addr = a; dm_wdata = v;
    #1 chk("R8 hit flag on store", 16'(dm_hit), 16'(h));
    commit();
    if (h) mdl[a[4:0]] = v;
    dm_en = 1; dm_addr = a;
    #1;
    chk("R8 load data", 16'(dm_rdata), h ? 16'(mdl[a[4:0]]) : 16'h0);
    chk("R8 hit flag on load", 16'(dm_hit), 16'(h));
    commit();
  endtask

  initial begin
    logic [15:0] pv [4];
    logic [5:0]  dv [3];
    logic [5:0]  iv [3];
    logic [15:0] xa [5];
    string       mt [4];
    pv = '{16'h0000, 16'hFFFF, 16'h1234, 16'h00FF};
    dv = '{6'd0, 6'd63, 6'd17};
    iv = '{6'd1, 6'd63, 6'd0};
    xa = '{16'h0100, 16'h0105, 16'hFFFF, 16'h8000, 16'h0020};
    mt = '{"R4 plain", "R5 post-increment", "R6 pre-decrement", "R7 displacement"};

    quiet();
    rd_a_idx = 0; rd_b_idx = 0; rst_n = 0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1 chk("R11 idle error flag", 16'(err), 16'h0);
    sweep_regs("R1 reset value");

    // R2/R3: plain writes, old value visible during the write cycle
    for (int i = 0; i < 32; i++) begin
      wr_en = 1; wr_idx = 5'(i); wr_data = 8'(i * 37 + 5); rd_a_idx = 5'(i);
      #1 chk("R2 same-cycle read returns old value", 16'(rd_a_data), 16'(mdl[i]));
      commit();
      mdl[i] = 8'(i * 37 + 5);
      rd_a_idx = 5'(i);
      #1 chk("R3 write lands after one edge", 16'(rd_a_data), 16'(mdl[i]));
    end
    sweep_regs("R2 both read ports");

    // R3: immediate-target restriction
    for (int i = 0; i < 32; i++) begin
      wr_en = 1; wr_imm = 1; wr_idx = 5'(i); wr_data = ~8'(i * 37 + 5);
      #1 chk("R3 immediate target error", 16'(err), 16'(i < 16));
      commit();
      if (i >= 16) mdl[i] = ~8'(i * 37 + 5);
      rd_a_idx = 5'(i);
      #1 chk("R3 immediate target result", 16'(rd_a_data), 16'(mdl[i]));
    end

    // R4-R7: pointer modes over all selects and corner values
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        for (int vi = 0; vi < 4; vi++) begin
          for (int di = 0; di < 3; di++) begin
            int          b;
            logic [15:0] p, ea, nv;
            bit          ill, upd;
            b = 26 + 2 * (s % 3);
            if (s < 3) load_pair(b, pv[vi]);
            p   = (s < 3) ? pair(b) : 16'h0;
            ill = (s == 3) || (s == 0 && m == 3);
            upd = !ill && (m == 1 || m == 2);
            ea  = p; nv = p;
            if (m == 1) nv = p + 16'd1;
            if (m == 2) begin nv = p - 16'd1; ea = nv; end
            if (m == 3 && s != 0) ea = p + 16'(dv[di]);
            if (s == 3) ea = 16'h0;
            ag_en = 1; ag_sel = 2'(s); ag_mode = 2'(m); ag_disp = dv[di];
            #1;
            chk((s == 3) ? "R4 reserved select address" : mt[m], ag_addr, ea);
            chk("R11 pointer request legality", 16'(err), 16'(ill));
            commit();
            if (upd) begin
              mdl[b] = nv[7:0];
              mdl[b + 1] = nv[15:8];
            end
            if (s < 3) check_pair((s == 3) ? "R4 reserved select" : mt[m], b);
          end
        end
      end
    end
    sweep_regs("R4 reserved select leaves registers");

    // R8: data window sweep and addresses outside it
    for (int a = 0; a < 40; a++) do_dm(16'(a));
    for (int k = 0; k < 5; k++) do_dm(xa[k]);
    sweep_regs("R8 out-of-window stores ignored");

    // R9: word immediate over every base
    for (int b = 0; b < 32; b++) begin
      for (int sb = 0; sb < 2; sb++) begin
        for (int k = 0; k < 3; k++) begin
          bit          ok;
          logic [15:0] p, r;
          ok = (b >= 24) && (b % 2 == 0);
          p  = pair(b);
          r  = sb ? (p - 16'(iv[k])) : (p + 16'(iv[k]));
          iw_en = 1; iw_sub = sb[0]; iw_base = 5'(b); iw_imm = iv[k];
          #1 chk("R9 base legality", 16'(err), 16'(!ok));
          commit();
          if (ok) begin
            mdl[b] = r[7:0];
            mdl[b + 1] = r[15:8];
          end
          check_pair("R9 word immediate result", b);
        end
      end
    end
    load_pair(24, 16'hFFFF);
    iw_en = 1; iw_base = 5'd24; iw_imm = 6'd1;
    commit();
    mdl[24] = 8'h00; mdl[25] = 8'h00;
    check_pair("R9 add wraps", 24);
    load_pair(30, 16'h0000);
    iw_en = 1; iw_sub = 1; iw_base = 5'd30; iw_imm = 6'd1;
    commit();
    mdl[30] = 8'hFF; mdl[31] = 8'hFF;
    check_pair("R9 subtract wraps", 30);

    // R10: write priority on a shared register
    for (int sc = 0; sc < 4; sc++) begin
      logic [15:0] p, ir, ar;
      load_pair(28, 16'h12F0);
      p  = pair(28);
      ir = p + 16'd5;
      ar = p + 16'd1;
      ag_en = 1; ag_sel = 2'd1; ag_mode = 2'd1;
      iw_en = (sc < 3); iw_base = 5'd28; iw_imm = 6'd5;
      dm_en = 1; dm_we = (sc < 2) || (sc == 3);
      dm_addr = (sc == 3) ? 16'd29 : 16'd28; dm_wdata = 8'hA5;
      wr_en = (sc == 0); wr_idx = 5'd28; wr_data = 8'h3C;
      commit();
      case (sc)
        0: begin mdl[28] = 8'h3C;    mdl[29] = ir[15:8]; end
        1: begin mdl[28] = 8'hA5;    mdl[29] = ir[15:8]; end
        2: begin mdl[28] = ir[7:0];  mdl[29] = ir[15:8]; end
        default: begin mdl[28] = ar[7:0]; mdl[29] = 8'hA5; end
      endcase
      check_pair("R10 write priority", 28);
    end

    // R11: disabled ports with illegal-looking inputs
    ag_sel = 2'd3; ag_mode = 2'd3; iw_base = 5'd1; wr_imm = 1; wr_idx = 5'd0;
    dm_we = 1; dm_addr = 16'd5; dm_wdata = 8'hEE;
    #1;
    chk("R11 disabled ports raise no error", 16'(err), 16'h0);
    chk("R11 disabled data port no hit", 16'(dm_hit), 16'h0);
    commit();
    sweep_regs("R11 disabled ports change nothing");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end
endmodule